// File: doc/BRIEF.md
# Ring Slot Arbiter with Forced Idle

This block owns the ring output register of one ring node. On every clock it picks one of three things for the next output slot. It can pass the incoming ring transaction through unchanged. It can insert a local transaction, which is either a request from the core or a read response that is ready to go. Or it can leave the slot empty. A valid incoming transaction that neither local buffer accepted in that cycle is always passed through. This covers traffic for other nodes and traffic this node cannot store because the buffer it targets is full. The buffers report acceptance through two take flags. The arbiter does not decode addresses itself.

A local transaction may only be inserted into a free slot. A slot is free when the ring input carried nothing, or when a local buffer took the incoming transaction in that same cycle. If a core request and a ready response both wait for free slots, they take turns. Each winner receives a one-cycle grant pulse, and its fields appear on the output one clock later.

A run counter keeps the ring from being saturated. It counts the slots in which this node fills an empty input slot with its own traffic. When the count reaches the limit, further insertion is held back until the output carries an empty slot. Any empty output slot clears the counter.

Top module: `ring_slot_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next output slot is invalid and the run counter returns to zero. After reset, up to `IDLE_LIMIT` insertions into empty input slots can follow in a row.
- R2: A valid input that neither `f2c_take` nor `c2f_take` claims appears on the output one clock later with the same opcode, address and data. No grant is given in that cycle.
- R3: A free slot (input invalid, or input claimed by a take flag) with no local transaction granted yields an invalid output one clock later.
- R4: When `creq_grant` is high, the next output slot carries the core request's opcode, address and data.
- R5: When `rrsp_grant` is high, the next output slot carries opcode 2'b01 (read response) with the response address and data. Opcode codes are read 00, read response 01, write 10, write broadcast 11.
- R6: When both sources wait in consecutive free slots, grants alternate between them. The first grant after reset goes to the read response.
- R7: After `IDLE_LIMIT` (default 4) insertions into invalid input slots with no invalid output slot in between, no grant is given until an invalid output slot has been sent.
- R8: Any invalid output slot clears the run counter, so a full run of `IDLE_LIMIT` insertions is possible again afterwards.
- R9: Forwarding, and insertion into a slot whose input was claimed by a take flag, leave the run counter unchanged.
- R10: At most one grant is high in a cycle, and a grant is only given when the slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rin_valid | input | 1 | Ring input slot valid |
| rin_op | input | 2 | Ring input opcode |
| rin_addr | input | ADDR_W | Ring input address |
| rin_data | input | DATA_W | Ring input data |
| f2c_take | input | 1 | Inbound buffer accepts the current input |
| c2f_take | input | 1 | Outbound buffer accepts the current input (matching response) |
| creq_valid | input | 1 | Core request waiting |
| creq_op | input | 2 | Core request opcode |
| creq_addr | input | ADDR_W | Core request address |
| creq_data | input | DATA_W | Core request data |
| creq_grant | output | 1 | Core request inserted this cycle |
| rrsp_valid | input | 1 | Ready read response waiting |
| rrsp_addr | input | ADDR_W | Read response address |
| rrsp_data | input | DATA_W | Read response data |
| rrsp_grant | output | 1 | Read response inserted this cycle |
| rout_valid | output | 1 | Ring output slot valid |
| rout_op | output | 2 | Ring output opcode |
| rout_addr | output | ADDR_W | Ring output address |
| rout_data | output | DATA_W | Ring output data |

## Verification
The assertions assume that a take flag is only raised together with a valid ring input. They also assume that a waiting source keeps its valid high until it is granted. The stimulus obeys both rules. Take flags are drawn only in cycles whose input is valid, and each source's valid is dropped only after its grant has been seen. Directed phases push the counter to its limit through empty input slots, then through claimed input slots, and then hold both sources busy together. These phases come before a long random phase.

// File: rtl/ras_pkg.sv
// Package: shared opcode type for the ring slot arbiter.
// Assumes a two-bit opcode field on both ring and core sides.
package ras_pkg;
    typedef enum logic [1:0] {
        OP_RD       = 2'b00,
        OP_RD_RSP   = 2'b01,
        OP_WR       = 2'b10,
        OP_WR_BCAST = 2'b11
    } ring_op_e;
endpackage

// File: rtl/ras_idle_guard.sv
// Module: ras_idle_guard
// Counts insertions made into empty input slots and raises hold_off
// once LIMIT of them have happened in a row. Any invalid output slot
// clears the count. Assumes out_valid_nxt is the value loaded into the
// output register at this edge.
module ras_idle_guard #(
    parameter int LIMIT = 4,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_valid_nxt,
    output logic hold_off
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // Next count: clear on empty output, step on self-filled empty input.
    always_comb begin
        cnt_d = cnt_q;
        if (!out_valid_nxt)
            cnt_d = '0;
        else if (!in_valid && cnt_q != CW'(LIMIT))
            cnt_d = cnt_q + 1'b1;
    end

    // Count register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hold_off = (cnt_q == CW'(LIMIT));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_nxt |=> cnt_q == '0);
    p_hold_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_valid_nxt) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/ras_pick.sv
// Module: ras_pick
// Round-robin choice between a waiting core request and a waiting
// read response. Grants only while allow is high. The source just
// served loses priority. After reset the response goes first.
module ras_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic allow,
    input  logic core_valid,
    input  logic rsp_valid,
    output logic core_gnt,
    output logic rsp_gnt
);
    logic rsp_first_q;

    // Grant decision for the current slot.
    always_comb begin
        core_gnt = 1'b0;
        rsp_gnt  = 1'b0;
        if (allow) begin
            if (core_valid && rsp_valid) begin
                rsp_gnt  = rsp_first_q;
                core_gnt = !rsp_first_q;
            end else begin
                core_gnt = core_valid;
                rsp_gnt  = rsp_valid;
            end
        end
    end

    // Priority pointer: the other source leads after each grant.
    always_ff @(posedge clk) begin
        if (!rst_n)        rsp_first_q <= 1'b1;
        else if (core_gnt) rsp_first_q <= 1'b1;
        else if (rsp_gnt)  rsp_first_q <= 1'b0;
    end

    p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(allow && core_valid && rsp_valid && rsp_gnt)
         && allow && core_valid && rsp_valid) |-> core_gnt);
    p_alternate_core_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(allow && core_valid && rsp_valid && core_gnt)
         && allow && core_valid && rsp_valid) |-> rsp_gnt);
endmodule

// File: rtl/ras_slot_reg.sv
// Module: ras_slot_reg
// Output slot register. Reset empties the slot. Fields of an empty
// slot keep their old values and have no meaning.
module ras_slot_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_valid,
    input  logic [1:0]        nxt_op,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [DATA_W-1:0] nxt_data,
    output logic              q_valid,
    output logic [1:0]        q_op,
    output logic [ADDR_W-1:0] q_addr,
    output logic [DATA_W-1:0] q_data
);
    // Valid bit with reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= nxt_valid;
    end

    // Payload fields, loaded only with a valid slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_op   <= '0;
            q_addr <= '0;
            q_data <= '0;
        end else if (nxt_valid) begin
            q_op   <= nxt_op;
            q_addr <= nxt_addr;
            q_data <= nxt_data;
        end
    end
endmodule

// File: rtl/ring_slot_arbiter.sv
// Module: ring_slot_arbiter
// Top level. Chooses, per cycle, between forwarding the ring input,
// inserting a local transaction, or sending an empty slot, and
// registers the choice. Assumes take flags are only raised with a
// valid input and that local sources hold valid until granted.
module ring_slot_arbiter #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int IDLE_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rin_valid,
    input  logic [1:0]        rin_op,
    input  logic [ADDR_W-1:0] rin_addr,
    input  logic [DATA_W-1:0] rin_data,
    input  logic              f2c_take,
    input  logic              c2f_take,
    input  logic              creq_valid,
    input  logic [1:0]        creq_op,
    input  logic [ADDR_W-1:0] creq_addr,
    input  logic [DATA_W-1:0] creq_data,
    output logic              creq_grant,
    input  logic              rrsp_valid,
    input  logic [ADDR_W-1:0] rrsp_addr,
    input  logic [DATA_W-1:0] rrsp_data,
    output logic              rrsp_grant,
    output logic              rout_valid,
    output logic [1:0]        rout_op,
    output logic [ADDR_W-1:0] rout_addr,
    output logic [DATA_W-1:0] rout_data
);
    import ras_pkg::*;

    logic              taken;
    logic              pass_through;
    logic              slot_free;
    logic              hold_off;
    logic              nxt_valid;
    logic [1:0]        nxt_op;
    logic [ADDR_W-1:0] nxt_addr;
    logic [DATA_W-1:0] nxt_data;

    // Slot classification for this cycle.
    always_comb begin
        taken        = rin_valid && (f2c_take || c2f_take);
        pass_through = rin_valid && !taken;
        slot_free    = !pass_through;
    end

    ras_idle_guard #(.LIMIT(IDLE_LIMIT)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rin_valid),
        .out_valid_nxt(nxt_valid),
        .hold_off     (hold_off)
    );

    ras_pick u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (slot_free && !hold_off),
        .core_valid(creq_valid),
        .rsp_valid (rrsp_valid),
        .core_gnt  (creq_grant),
        .rsp_gnt   (rrsp_grant)
    );

    // Next slot contents: forward, response, core request, or empty.
    always_comb begin
        nxt_valid = 1'b0;
        nxt_op    = rin_op;
        nxt_addr  = rin_addr;
        nxt_data  = rin_data;
        if (pass_through) begin
            nxt_valid = 1'b1;
        end else if (rrsp_grant) begin
            nxt_valid = 1'b1;
            nxt_op    = OP_RD_RSP;
            nxt_addr  = rrsp_addr;
            nxt_data  = rrsp_data;
        end else if (creq_grant) begin
            nxt_valid = 1'b1;
            nxt_op    = creq_op;
            nxt_addr  = creq_addr;
            nxt_data  = creq_data;
        end
    end

    ras_slot_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_valid(nxt_valid),
        .nxt_op   (nxt_op),
        .nxt_addr (nxt_addr),
        .nxt_data (nxt_data),
        .q_valid  (rout_valid),
        .q_op     (rout_op),
        .q_addr   (rout_addr),
        .q_data   (rout_data)
    );

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !rout_valid);
    p_forward_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rin_valid && !f2c_take && !c2f_take) |=> (rout_valid
            && rout_op == $past(rin_op) && rout_addr == $past(rin_addr)
            && rout_data == $past(rin_data)));
    p_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rin_valid && !f2c_take && !c2f_take) && !creq_grant && !rrsp_grant)
        |=> !rout_valid);
    p_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
        creq_grant |=> (rout_valid && rout_op == $past(creq_op)
            && rout_addr == $past(creq_addr) && rout_data == $past(creq_data)));
    p_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rrsp_grant |=> (rout_valid && rout_op == 2'b01
            && rout_addr == $past(rrsp_addr) && rout_data == $past(rrsp_data)));
    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off |-> (!creq_grant && !rrsp_grant));
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({creq_grant, rrsp_grant}));
    p_grant_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (creq_grant || rrsp_grant) |-> (!rin_valid || f2c_take || c2f_take));
endmodule

// File: tb/ring_slot_arbiter_test.sv
`timescale 1ns/1ps
module ring_slot_arbiter_test;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rin_valid = 0, f2c_take = 0, c2f_take = 0;
    logic [1:0] rin_op = 0, creq_op = 0;
    logic [AW-1:0] rin_addr = 0, creq_addr = 0, rrsp_addr = 0;
    logic [DW-1:0] rin_data = 0, creq_data = 0, rrsp_data = 0;
    logic creq_valid = 0, rrsp_valid = 0;
    logic creq_grant, rrsp_grant, rout_valid;
    logic [1:0] rout_op;
    logic [AW-1:0] rout_addr;
    logic [DW-1:0] rout_data;

    always #2.5 clk = ~clk;

    ring_slot_arbiter #(.ADDR_W(AW), .DATA_W(DW), .IDLE_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n),
        .rin_valid(rin_valid), .rin_op(rin_op), .rin_addr(rin_addr), .rin_data(rin_data),
        .f2c_take(f2c_take), .c2f_take(c2f_take),
        .creq_valid(creq_valid), .creq_op(creq_op), .creq_addr(creq_addr),
        .creq_data(creq_data), .creq_grant(creq_grant),
        .rrsp_valid(rrsp_valid), .rrsp_addr(rrsp_addr), .rrsp_data(rrsp_data),
        .rrsp_grant(rrsp_grant),
        .rout_valid(rout_valid), .rout_op(rout_op), .rout_addr(rout_addr),
        .rout_data(rout_data)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state kept as plain integers.
    int run_len = 0;
    bit rsp_leads = 1;
    bit e_valid = 0;
    logic [1:0] e_op = 0;
    logic [AW-1:0] e_addr = 0;
    logic [DW-1:0] e_data = 0;
    string e_tag = "R1";

    // Compare the registered output against the expected slot.
    task automatic check_out();
        n_tests++;
        if (rout_valid !== e_valid ||
            (e_valid && (rout_op !== e_op || rout_addr !== e_addr || rout_data !== e_data))) begin
            n_fail++;
            $display("FAIL %s: out v=%0b op=%0d a=%h d=%h expected v=%0b op=%0d a=%h d=%h",
                     e_tag, rout_valid, rout_op, rout_addr, rout_data,
                     e_valid, e_op, e_addr, e_data);
        end
    endtask

    // One cycle: check output, apply inputs, check grants, predict next slot.
    task automatic cycle(input bit rv, input bit tk, input bit cv, input bit sv,
                         input string tag);
        bit free, hold, allow, gc, gr;
        @(negedge clk);
        if (rst_n) check_out();
        rin_valid = rv;
        rin_op    = 2'($urandom_range(0, 3));
        rin_addr  = AW'($urandom);
        rin_data  = DW'($urandom);
        f2c_take  = rv && tk && $urandom_range(0, 1) == 1;
        c2f_take  = rv && tk && !f2c_take;
        creq_valid = cv;
        if (cv) begin
            creq_op   = 2'($urandom_range(0, 3));
            creq_addr = AW'($urandom);
            creq_data = DW'($urandom);
        end
        rrsp_valid = sv;
        if (sv) begin
            rrsp_addr = AW'($urandom);
            rrsp_data = DW'($urandom);
        end
        #1;
        free  = !rv || tk;
        hold  = (run_len >= LIM);
        allow = free && !hold;
        gc = 0; gr = 0;
        if (allow) begin
            if (cv && sv) begin gr = rsp_leads; gc = !rsp_leads; end
            else begin gc = cv; gr = sv; end
        end
        n_tests++;
        if (creq_grant !== gc || rrsp_grant !== gr) begin
            n_fail++;
            $display("FAIL %s/R10: grants core=%0b rsp=%0b expected core=%0b rsp=%0b",
                     (cv && sv) ? "R6" : (hold ? "R7" : tag),
                     creq_grant, rrsp_grant, gc, gr);
        end
        if (rv && !tk) begin
            e_valid = 1; e_op = rin_op; e_addr = rin_addr; e_data = rin_data; e_tag = "R2";
        end else if (gr) begin
            e_valid = 1; e_op = 2'b01; e_addr = rrsp_addr; e_data = rrsp_data; e_tag = "R5";
        end else if (gc) begin
            e_valid = 1; e_op = creq_op; e_addr = creq_addr; e_data = creq_data; e_tag = "R4";
        end else begin
            e_valid = 0; e_tag = hold ? "R7" : "R3";
        end
        if (rv && tk && !gc && !gr) e_tag = "R3";
        if (!e_valid) run_len = 0;
        else if (!rv) run_len++;
        if (gc) rsp_leads = 1;
        else if (gr) rsp_leads = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset empties the output slot.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        e_valid = 0; e_tag = "R1";
        run_len = 0; rsp_leads = 1;
        // R2: foreign traffic passes through while the core waits.
        for (int i = 0; i < 6; i++) cycle(1, 0, 1, 0, "R2");
        // R4, R7: core-only insertion into empty input slots hits the limit.
        for (int i = 0; i < 12; i++) cycle(0, 0, 1, 0, "R4");
        // R8: an empty output slot clears the run; a full run follows.
        cycle(0, 0, 0, 0, "R8");
        for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0, "R8");
        // R9: insertion into claimed slots never counts toward the run.
        for (int i = 0; i < 10; i++) cycle(1, 1, 1, 0, "R9");
        // R3: claimed slot with nothing to insert stays empty.
        for (int i = 0; i < 3; i++) cycle(1, 1, 0, 0, "R3");
        // R5, R6: both sources wait, grants alternate.
        for (int i = 0; i < 10; i++) cycle(0, 0, 1, 1, "R6");
        for (int i = 0; i < 6; i++) cycle(1, 1, 1, 1, "R6");
        // R5: response alone.
        for (int i = 0; i < 3; i++) cycle(0, 0, 0, 1, "R5");
        // Mid-run reset, R1: run counter and priority restart.
        @(negedge clk);
        check_out();
        rst_n = 1'b0;
        rin_valid = 0; creq_valid = 0; rrsp_valid = 0; f2c_take = 0; c2f_take = 0;
        @(negedge clk);
        n_tests++;
        if (rout_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out valid %0b expected 0 after reset", rout_valid);
        end
        rst_n = 1'b1;
        e_valid = 0; e_tag = "R1"; run_len = 0; rsp_leads = 1;
        for (int i = 0; i < 6; i++) cycle(0, 0, 1, 1, "R1");
        // Random mix of all traffic kinds.
        for (int i = 0; i < 3000; i++) begin
            bit rv = $urandom_range(0, 2) == 0;
            cycle(rv, rv && $urandom_range(0, 1) == 1,
                  $urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0, "R10");
        end
        @(negedge clk);
        check_out();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule